// File: doc/BRIEF.md
# Word-Parallel "corn!" Pattern Detector

The block watches a stream of 32-bit words, each holding four 8-bit characters, and finds every occurrence of the five-character string `corn!` (the `PATTERN` parameter). The stream order of characters inside a word runs from the most significant byte down. Because the pattern is one character longer than a word, every occurrence starts in one word and ends in a later accepted word. The starting position can be any of the four byte lanes.

At the end of each accepted word, the block records how much of the pattern is sitting at the tail of that word: `c`, `co`, `cor` or `corn`, or nothing. On the next accepted word it checks whether the leading characters finish that partial match. When they do, it raises the alert for the lane that holds the final `!`. The same word is also searched for a new tail prefix, so occurrences that follow one another with no gap are all found. The lane alerts are counted, and the count is added to an 8-bit match counter. That counter can be cleared or loaded from outside.

Top module: `corn_word_detector`

## Requirements
- R1: Character 0, the first in stream order, is `word_data[31:24]`, and character 3 is `word_data[7:0]`. The first pattern character is the most significant byte of `PATTERN`.
- R2: When `word_valid` is high, the block stores the length k (1 to 4) of the pattern prefix that ends the word in its last k characters, or 0 if there is none. At most one such length can match.
- R3: With a stored length k, an accepted word whose first 5-k characters equal the rest of the pattern raises `lane_alert[4-k]` in that same cycle. Bit i of `lane_alert` is character lane i, so the bits map as k=4→bit 0, k=3→bit 1, k=2→bit 2 and k=1→bit 3. The characters after that lane do not matter.
- R4: An accepted word that does not continue the stored prefix raises no alert. The stored length then comes only from that word's own tail, and is 0 if the tail holds no prefix.
- R5: While `word_valid` is low, all lane alerts are 0, the stored length holds, and the counter does not increment.
- R6: `alert` is the OR of the four lane alerts. `hit_inc` is the number of lane alerts set. At most one lane is set in any cycle.
- R7: When neither clear nor load is active, `match_count` increases by `hit_inc` at the next rising edge, modulo 256.
- R8: `cnt_clr` forces the count to 0 at the next edge and overrides `cnt_load`. `cnt_load` writes `cnt_load_val` and overrides the increment.
- R9: Occurrences that follow one another with no gap, such as `corn!corn!corn!` laid across words, are each counted.
- R10: An active-low `rst_n` clears the counter to 0 and the stored prefix length to 0. A prefix seen before reset is not completed after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Current word is accepted |
| word_data | input | 32 | Four characters, first one in the top byte |
| cnt_clr | input | 1 | Synchronous counter clear |
| cnt_load | input | 1 | Synchronous counter load |
| cnt_load_val | input | 8 | Value written by a load |
| lane_alert | output | 4 | Completion flag per character lane |
| alert | output | 1 | Any lane alert |
| hit_inc | output | 3 | Number of lane alerts this cycle |
| match_count | output | 8 | Accumulated match count |

## Verification
In a single cycle, a word can both complete the stored prefix through its leading characters and leave a new prefix in its trailing characters. The bench provokes this with words such as `n!co` and `rn!c` that follow partial matches. It then checks two things: the alert appears in the expected lane, and the next word completes the new prefix as well. The counter adds a further overlap, because an increment from a completing word can land in the same cycle as a clear or a load. The bench drives such completing words together with `cnt_clr` and `cnt_load`, and checks that the value written wins over the increment.

// File: rtl/corn_word_detector.sv
module corn_word_detector #(
  parameter int          CHAR_W  = 8,
  parameter int          LANES   = 4,
  parameter int          CNT_W   = 8,
  parameter logic [39:0] PATTERN = "corn!"
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         word_valid,
  input  logic [CHAR_W*LANES-1:0]      word_data,
  input  logic                         cnt_clr,
  input  logic                         cnt_load,
  input  logic [CNT_W-1:0]             cnt_load_val,
  output logic [LANES-1:0]             lane_alert,
  output logic                         alert,
  output logic [$clog2(LANES+1)-1:0]   hit_inc,
  output logic [CNT_W-1:0]             match_count
);
  localparam int WORD_W  = CHAR_W * LANES;
  localparam int PAT_LEN = LANES + 1;
  localparam int PEND_W  = $clog2(LANES + 1);
  localparam int INC_W   = $clog2(LANES + 1);

  logic [PEND_W-1:0] pend_len;
  logic [PEND_W-1:0] pend_nxt;
  logic [LANES-1:0]  tail_hit;
  logic [LANES-1:0]  cont_hit;

  // tail_hit[k-1]: last k characters equal the first k pattern characters
  // cont_hit[l]: stored prefix finishes with its final character in lane l
  for (genvar k = 1; k <= LANES; k++) begin : g_tail
    assign tail_hit[k-1] =
      word_data[k*CHAR_W-1:0] == PATTERN[PAT_LEN*CHAR_W-1 -: k*CHAR_W];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_cont
    assign cont_hit[l] =
      (pend_len == PEND_W'(PAT_LEN-1-l)) &&
      (word_data[WORD_W-1 -: (l+1)*CHAR_W] == PATTERN[(l+1)*CHAR_W-1:0]);
  end

  assign lane_alert = word_valid ? cont_hit : '0;
  assign alert      = |lane_alert;

  always_comb begin
    pend_nxt = '0;
    for (int k = 1; k <= LANES; k++)
      if (tail_hit[k-1]) pend_nxt = PEND_W'(k);
  end

  always_comb begin
    hit_inc = '0;
    for (int l = 0; l < LANES; l++)
      hit_inc = hit_inc + INC_W'(lane_alert[l]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_len <= '0;
    else if (word_valid) pend_len <= pend_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        match_count <= '0;
    else if (cnt_clr)  match_count <= '0;
    else if (cnt_load) match_count <= cnt_load_val;
    else if (alert)    match_count <= match_count + CNT_W'(hit_inc);
  end
endmodule

module corn_word_detector_chk #(
  parameter int LANES = 4,
  parameter int CNT_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       word_valid,
  input logic                       cnt_clr,
  input logic                       cnt_load,
  input logic [CNT_W-1:0]           cnt_load_val,
  input logic [LANES-1:0]           lane_alert,
  input logic [$clog2(LANES+1)-1:0] hit_inc,
  input logic [CNT_W-1:0]           match_count
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !word_valid |-> lane_alert == '0); // R5
  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lane_alert)); // R6
  AST_INC_COUNTS_LANES: assert property (@(posedge clk) disable iff (!rst_n) hit_inc == $countones(lane_alert)); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!cnt_clr && !cnt_load) |=> match_count == CNT_W'($past(match_count) + CNT_W'($past(hit_inc)))); // R7
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n) cnt_clr |=> match_count == '0); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n) (!cnt_clr && cnt_load) |=> match_count == $past(cnt_load_val)); // R8
endmodule

bind corn_word_detector corn_word_detector_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .cnt_clr(cnt_clr),
  .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .lane_alert(lane_alert),
  .hit_inc(hit_inc), .match_count(match_count)
);

// File: tb/sim_corn_word_detector.sv
module sim_corn_word_detector;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        cnt_clr = 1'b0;
  logic        cnt_load = 1'b0;
  logic [7:0]  cnt_load_val = '0;
  logic [3:0]  lane_alert;
  logic        alert;
  logic [2:0]  hit_inc;
  logic [7:0]  match_count;

  int checks = 0;
  int fails  = 0;

  corn_word_detector u0 (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .cnt_clr(cnt_clr), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .lane_alert(lane_alert), .alert(alert), .hit_inc(hit_inc),
    .match_count(match_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {valid, word, expected lane_alert, expected count after the edge}
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b1, "corn", 4'b0000, 8'd0},
    {1'b1, "!abc", 4'b0001, 8'd1},
    {1'b1, "xcor", 4'b0000, 8'd1},
    {1'b1, "n!zz", 4'b0010, 8'd2},
    {1'b1, "zzco", 4'b0000, 8'd2},
    {1'b0, "xxxx", 4'b0000, 8'd2},
    {1'b1, "rn!c", 4'b0100, 8'd3},
    {1'b1, "orn!", 4'b1000, 8'd4},
    {1'b1, "corn", 4'b0000, 8'd4},
    {1'b1, "abcd", 4'b0000, 8'd4},
    {1'b1, "!xyz", 4'b0000, 8'd4},
    {1'b1, "bcor", 4'b0000, 8'd4},
    {1'b1, "n!co", 4'b0010, 8'd5},
    {1'b1, "rn!c", 4'b0100, 8'd6},
    {1'b1, "orn!", 4'b1000, 8'd7},
    {1'b1, "corn", 4'b0000, 8'd7},
    {1'b1, "corn", 4'b0000, 8'd7},
    {1'b1, "!!!!", 4'b0001, 8'd8},
    {1'b1, "zcor", 4'b0000, 8'd8},
    {1'b1, "nxzz", 4'b0000, 8'd8}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic drive(input logic v, input logic [31:0] d);
    @(negedge clk);
    word_valid = v;
    word_data  = d;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 count", 32'(match_count), 32'd0);
    check("R10 lanes", 32'(lane_alert), 32'd0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R9 table walk
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][44], VEC[i][43:12]);
      check("R3 R4 R5 lanes", 32'(lane_alert), 32'(VEC[i][11:8]));
      check("R6 alert", 32'(alert), 32'(|VEC[i][11:8]));
      check("R6 inc", 32'(hit_inc), 32'($countones(VEC[i][11:8])));
      @(negedge clk);
      check("R7 R9 count", 32'(match_count), 32'(VEC[i][7:0]));
    end

    // R8 load beats a same-cycle increment
    drive(1'b1, "corn");
    drive(1'b1, "!aaa");
    cnt_load = 1'b1; cnt_load_val = 8'hFE;
    check("R8 lane", 32'(lane_alert), 32'd1);
    @(negedge clk);
    cnt_load = 1'b0;
    check("R8 load", 32'(match_count), 32'hFE);

    // R7 wrap modulo 256
    word_data = "corn";
    @(negedge clk);
    word_data = "!bbb";
    @(negedge clk);
    check("R7 step", 32'(match_count), 32'hFF);
    word_data = "corn";
    @(negedge clk);
    word_data = "!ccc";
    @(negedge clk);
    check("R7 wrap", 32'(match_count), 32'h00);

    // R8 clear beats load and increment
    cnt_load = 1'b1; cnt_load_val = 8'h55;
    @(negedge clk);
    cnt_load = 1'b0;
    check("R8 load2", 32'(match_count), 32'h55);
    word_data = "corn";
    @(negedge clk);
    word_data = "!ddd"; cnt_clr = 1'b1; cnt_load = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0; cnt_load = 1'b0;
    check("R8 clr", 32'(match_count), 32'h00);

    // R5 idle between prefix and completion with counter held
    word_data = "xxco";
    @(negedge clk);
    word_valid = 1'b0; word_data = "rn!x";
    #1;
    check("R5 idle lanes", 32'(lane_alert), 32'd0);
    @(negedge clk);
    check("R5 idle count", 32'(match_count), 32'h00);
    word_valid = 1'b1;
    #1;
    check("R5 held prefix", 32'(lane_alert), 32'b0100);
    @(negedge clk);
    check("R5 count", 32'(match_count), 32'h01);

    // R10 reset drops a stored prefix
    word_data = "corn";
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 count cleared", 32'(match_count), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    word_data = "!eee";
    #1;
    check("R10 no stale alert", 32'(lane_alert), 32'd0);
    @(negedge clk);
    check("R10 count stays", 32'(match_count), 32'd0);
    word_valid = 1'b0;

    finish_run();
  end
endmodule